// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer with Exception Vectoring

This block is the control unit of a multicycle processor datapath. Every instruction is broken into a series of one-cycle steps. A state register walks through those steps, and each state drives a fixed word of datapath strobes and selects: memory read and write, instruction-register capture, PC update (unconditional or branch-qualified), PC source, the two ALU operand selects, the ALU operation class, the destination-register select, the write-back source select, the register-file write enable, and the exception cause and saved-PC write enables.

Every instruction starts with the same two steps: instruction fetch, then decode with register read. After decode the sequence splits by opcode class into the memory-reference path, the register-to-register path, the branch-equal step or the jump step. It then returns to fetch.

An opcode outside the supported set, or an arithmetic overflow reported while a register-to-register operation executes, sends the sequencer to an exception state. That state records a cause code and stores the faulting PC. It does this by having the ALU take 4 away from the already-advanced PC. It also redirects the PC through the fourth PC-source input, which the datapath wires to the handler entry at 0x8000_0180.

The control word is registered. It is computed from the state that is about to be entered, so the word on the pins always belongs to the state shown on `state_o` and depends on nothing else.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: A high `rst` at a rising edge puts the sequencer in state 0 (fetch) with the fetch control word. This holds whatever state it was in.
- R2: Each state lasts exactly one cycle. State 0 is always followed by state 1 (decode), whatever the values of `opcode` and `alu_ovf`.
- R3: When leaving state 1, opcodes 0x23 and 0x2B go to state 2 (address computation), 0x00 goes to state 6 (execute), 0x04 goes to state 8 (branch) and 0x02 goes to state 9 (jump).
- R4: State 2 goes to state 3 (memory read) when the opcode is 0x23, and to state 5 (memory write) otherwise. State 3 goes to state 4 (load write-back). States 4 and 5 go to state 0.
- R5: Any opcode other than 0x00, 0x23, 0x2B, 0x04 and 0x02 seen when leaving state 1 leads to state 10 (undefined instruction).
- R6: States 10 and 11 are always followed by state 0.
- R7: State 6 goes to state 11 (overflow) when `alu_ovf` is high, and to state 7 (register write-back) otherwise. States 7, 8 and 9 go to state 0.
- R8: The control word in each non-exception state is as follows. Every field not listed is 0. ALU select B codes are 00 = register B, 01 = constant 4, 10 = immediate, 11 = shifted immediate. ALU op codes are 00 = add, 01 = subtract, 10 = function field.
  - Fetch: mem_rd, ir_wr, pc_wr, alu_b=01.
  - Decode: alu_b=11.
  - Address: alu_a, alu_b=10.
  - Memory read: mem_rd.
  - Load write-back: mem_to_reg, reg_wr.
  - Memory write: mem_wr.
  - Execute: alu_a, alu_op=10.
  - Register write-back: reg_dst, reg_wr.
  - Branch: alu_a, alu_op=01, pc_wr_cond, pc_src=01.
  - Jump: pc_wr, pc_src=10.
- R9: States 10 and 11 both assert cause_wr, epc_wr and pc_wr, with pc_src=11, alu_a=0, alu_b=01 and alu_op=01. `int_cause` is 0 in state 10 and 1 in state 11. Every other field is 0.
- R10: The control word depends only on the state. Changing `opcode` or `alu_ovf` has no effect on the word shown during the current state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Opcode field from the instruction register |
| alu_ovf | input | 1 | ALU signed-overflow flag |
| state_o | output | 4 | Current state number |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_wr | output | 1 | Instruction register load |
| pc_wr | output | 1 | Unconditional PC load |
| pc_wr_cond | output | 1 | PC load qualified by ALU zero |
| pc_src | output | 2 | PC source: 00 ALU, 01 ALU result register, 10 jump target, 11 handler |
| alu_a | output | 1 | ALU input A: 0 PC, 1 register A |
| alu_b | output | 2 | ALU input B select (codes in R8) |
| alu_op | output | 2 | ALU operation class (codes in R8) |
| reg_dst | output | 1 | Destination register: 0 rt field, 1 rd field |
| mem_to_reg | output | 1 | Write-back source: 0 ALU result, 1 memory data |
| reg_wr | output | 1 | Register file write enable |
| cause_wr | output | 1 | Cause register write enable |
| int_cause | output | 1 | Cause code: 0 undefined opcode, 1 overflow |
| epc_wr | output | 1 | Saved-PC register write enable |

## Verification
A rising edge moves `state_o` and the whole control word together, so both belong to the inputs that were present just before that edge.

The bench drives `opcode`, `alu_ovf` and `rst` on falling edges. Its reference model computes the state due after the next rising edge. At the following falling edge it compares both the state and the full control word against that prediction.

Opcodes and overflow are randomised in every state that must ignore them, which exercises R10 on each cycle. Reset is pulsed in the middle of instructions to show that it takes effect after exactly one edge.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int OP_W = 6;
  localparam int ST_W = 4;

  typedef enum logic [ST_W-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_MADDR  = 4'd2,
    S_MREAD  = 4'd3,
    S_LDWB   = 4'd4,
    S_MWRITE = 4'd5,
    S_EXEC   = 4'd6,
    S_RDONE  = 4'd7,
    S_BRANCH = 4'd8,
    S_JUMP   = 4'd9,
    S_UNDEF  = 4'd10,
    S_OVF    = 4'd11
  } st_e;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OP_LW    = 6'h23;
  localparam logic [OP_W-1:0] OP_SW    = 6'h2B;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OP_J     = 6'h02;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       ir_wr;
    logic       pc_wr;
    logic       pc_wr_cond;
    logic [1:0] pc_src;
    logic       alu_a;
    logic [1:0] alu_b;
    logic [1:0] alu_op;
    logic       reg_dst;
    logic       mem_to_reg;
    logic       reg_wr;
    logic       cause_wr;
    logic       int_cause;
    logic       epc_wr;
  } ctrl_t;

endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
  import mc_ctrl_pkg::*;
#(
  parameter int OPC_W = OP_W
) (
  input  st_e              cur,
  input  logic [OPC_W-1:0] op,
  input  logic             ovf,
  output st_e              nxt
);

  always_comb begin
    nxt = S_FETCH;
    unique case (cur)
      S_FETCH:  nxt = S_DECODE;
      S_DECODE: begin
        if (op == OP_LW || op == OP_SW) nxt = S_MADDR;
        else if (op == OP_RTYPE)        nxt = S_EXEC;
        else if (op == OP_BEQ)          nxt = S_BRANCH;
        else if (op == OP_J)            nxt = S_JUMP;
        else                            nxt = S_UNDEF;
      end
      S_MADDR:  nxt = (op == OP_LW) ? S_MREAD : S_MWRITE;
      S_MREAD:  nxt = S_LDWB;
      S_EXEC:   nxt = ovf ? S_OVF : S_RDONE;
      default:  nxt = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
  import mc_ctrl_pkg::*;
(
  input  st_e   st,
  output ctrl_t cw
);

  always_comb begin
    cw = '0;
    unique case (st)
      S_FETCH: begin
        cw.mem_rd = 1'b1;
        cw.ir_wr  = 1'b1;
        cw.pc_wr  = 1'b1;
        cw.alu_b  = 2'b01;
      end
      S_DECODE: cw.alu_b = 2'b11;
      S_MADDR: begin
        cw.alu_a = 1'b1;
        cw.alu_b = 2'b10;
      end
      S_MREAD:  cw.mem_rd = 1'b1;
      S_LDWB: begin
        cw.mem_to_reg = 1'b1;
        cw.reg_wr     = 1'b1;
      end
      S_MWRITE: cw.mem_wr = 1'b1;
      S_EXEC: begin
        cw.alu_a  = 1'b1;
        cw.alu_op = 2'b10;
      end
      S_RDONE: begin
        cw.reg_dst = 1'b1;
        cw.reg_wr  = 1'b1;
      end
      S_BRANCH: begin
        cw.alu_a      = 1'b1;
        cw.alu_op     = 2'b01;
        cw.pc_wr_cond = 1'b1;
        cw.pc_src     = 2'b01;
      end
      S_JUMP: begin
        cw.pc_wr  = 1'b1;
        cw.pc_src = 2'b10;
      end
      S_UNDEF, S_OVF: begin
        cw.cause_wr  = 1'b1;
        cw.int_cause = (st == S_OVF);
        cw.epc_wr    = 1'b1;
        cw.pc_wr     = 1'b1;
        cw.pc_src    = 2'b11;
        cw.alu_b     = 2'b01;
        cw.alu_op    = 2'b01;
      end
      default: cw = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [OP_W-1:0] opcode,
  input  logic            alu_ovf,
  output logic [ST_W-1:0] state_o,
  output logic            mem_rd,
  output logic            mem_wr,
  output logic            ir_wr,
  output logic            pc_wr,
  output logic            pc_wr_cond,
  output logic [1:0]      pc_src,
  output logic            alu_a,
  output logic [1:0]      alu_b,
  output logic [1:0]      alu_op,
  output logic            reg_dst,
  output logic            mem_to_reg,
  output logic            reg_wr,
  output logic            cause_wr,
  output logic            int_cause,
  output logic            epc_wr
);

  st_e   state_q;
  st_e   state_nx;
  st_e   state_d;
  ctrl_t cw_d;
  ctrl_t cw_q;

  mc_ctrl_next #(.OPC_W(OP_W)) u_next (
    .cur (state_q),
    .op  (opcode),
    .ovf (alu_ovf),
    .nxt (state_nx)
  );

  assign state_d = rst ? S_FETCH : state_nx;

  // Look-ahead decode: the word is registered alongside the state it belongs to.
  mc_ctrl_decode u_dec (
    .st (state_d),
    .cw (cw_d)
  );

  always_ff @(posedge clk) begin
    state_q <= state_d;
    cw_q    <= cw_d;
  end

  assign state_o    = state_q;
  assign mem_rd     = cw_q.mem_rd;
  assign mem_wr     = cw_q.mem_wr;
  assign ir_wr      = cw_q.ir_wr;
  assign pc_wr      = cw_q.pc_wr;
  assign pc_wr_cond = cw_q.pc_wr_cond;
  assign pc_src     = cw_q.pc_src;
  assign alu_a      = cw_q.alu_a;
  assign alu_b      = cw_q.alu_b;
  assign alu_op     = cw_q.alu_op;
  assign reg_dst    = cw_q.reg_dst;
  assign mem_to_reg = cw_q.mem_to_reg;
  assign reg_wr     = cw_q.reg_wr;
  assign cause_wr   = cw_q.cause_wr;
  assign int_cause  = cw_q.int_cause;
  assign epc_wr     = cw_q.epc_wr;

  logic seen_rst;
  always_ff @(posedge clk) begin
    if (rst) seen_rst <= 1'b1;
    else if (seen_rst !== 1'b1) seen_rst <= 1'b0;
  end

  p_reset_fetch_r1: assert property (@(posedge clk)
    rst |=> (state_o == 4'd0 && ir_wr && mem_rd));

  p_fetch_to_decode_r2: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
    state_o == 4'd0 |=> state_o == 4'd1);

  p_store_ends_r4: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
    state_o == 4'd5 |=> state_o == 4'd0);

  p_undef_vector_r5: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
    (state_o == 4'd1 && opcode != OP_RTYPE && opcode != OP_LW && opcode != OP_SW &&
     opcode != OP_BEQ && opcode != OP_J) |=> state_o == 4'd10);

  p_exc_return_r6: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
    (state_o == 4'd10 || state_o == 4'd11) |=> state_o == 4'd0);

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (rst || seen_rst !== 1'b1)
    (state_o == 4'd6 && alu_ovf) |=> (state_o == 4'd11 && !reg_wr));

  p_branch_word_r8: assert property (@(posedge clk) disable iff (seen_rst !== 1'b1)
    state_o == 4'd8 |-> (pc_wr_cond && !pc_wr && pc_src == 2'b01));

  p_mem_strobes_r8: assert property (@(posedge clk) disable iff (seen_rst !== 1'b1)
    $onehot0({mem_rd, mem_wr}));

  p_exc_word_r9: assert property (@(posedge clk) disable iff (seen_rst !== 1'b1)
    (state_o == 4'd10 || state_o == 4'd11) |->
      (cause_wr && epc_wr && pc_wr && pc_src == 2'b11 && int_cause == (state_o == 4'd11)));

endmodule

// File: tb/mc_ctrl_fsm_tb.sv
module mc_ctrl_fsm_tb;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = 6'h00;
  logic       alu_ovf = 1'b0;
  logic [3:0] state_o;
  logic       mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, alu_a, reg_dst;
  logic       mem_to_reg, reg_wr, cause_wr, int_cause, epc_wr;
  logic [1:0] pc_src, alu_b, alu_op;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  mc_ctrl_fsm u_dut (
    .clk(clk), .rst(rst), .opcode(opcode), .alu_ovf(alu_ovf),
    .state_o(state_o), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_wr(ir_wr),
    .pc_wr(pc_wr), .pc_wr_cond(pc_wr_cond), .pc_src(pc_src), .alu_a(alu_a),
    .alu_b(alu_b), .alu_op(alu_op), .reg_dst(reg_dst), .mem_to_reg(mem_to_reg),
    .reg_wr(reg_wr), .cause_wr(cause_wr), .int_cause(int_cause), .epc_wr(epc_wr)
  );

  // Bit order: mem_rd mem_wr ir_wr pc_wr pc_wr_cond pc_src alu_a alu_b alu_op
  //            reg_dst mem_to_reg reg_wr cause_wr int_cause epc_wr
  function automatic logic [17:0] want_word(int s);
    logic rd = 0, wr = 0, ir = 0, pw = 0, pwc = 0, a = 0, rdst = 0, m2r = 0;
    logic rw = 0, cw = 0, ic = 0, ew = 0;
    logic [1:0] ps = 0, b = 0, op = 0;
    case (s)
      0:  begin rd = 1; ir = 1; pw = 1; b = 2'b01; end
      1:  b = 2'b11;
      2:  begin a = 1; b = 2'b10; end
      3:  rd = 1;
      4:  begin m2r = 1; rw = 1; end
      5:  wr = 1;
      6:  begin a = 1; op = 2'b10; end
      7:  begin rdst = 1; rw = 1; end
      8:  begin a = 1; op = 2'b01; pwc = 1; ps = 2'b01; end
      9:  begin pw = 1; ps = 2'b10; end
      10, 11: begin cw = 1; ew = 1; pw = 1; ps = 2'b11; b = 2'b01; op = 2'b01; ic = (s == 11); end
      default: ;
    endcase
    return {rd, wr, ir, pw, pwc, ps, a, b, op, rdst, m2r, rw, cw, ic, ew};
  endfunction

  function automatic int step(int s, logic [5:0] op, logic ov);
    case (s)
      0: return 1;
      1: begin
        if (op == 6'h23 || op == 6'h2B) return 2;
        if (op == 6'h00) return 6;
        if (op == 6'h04) return 8;
        if (op == 6'h02) return 9;
        return 10;
      end
      2: return (op == 6'h23) ? 3 : 5;
      3: return 4;
      6: return ov ? 11 : 7;
      default: return 0;
    endcase
  endfunction

  function automatic string tag_of(int s, logic [5:0] op);
    case (s)
      0: return "R2";
      1: return (op == 6'h00 || op == 6'h23 || op == 6'h2B || op == 6'h04 || op == 6'h02) ? "R3" : "R5";
      2, 3, 4, 5: return "R4";
      10, 11: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h at %0t", req, got, exp, $time);
    end
  endtask

  logic [17:0] seen;
  assign seen = {mem_rd, mem_wr, ir_wr, pc_wr, pc_wr_cond, pc_src, alu_a, alu_b,
                 alu_op, reg_dst, mem_to_reg, reg_wr, cause_wr, int_cause, epc_wr};

  logic [5:0] script_op [10] = '{6'h00, 6'h23, 6'h2B, 6'h04, 6'h02, 6'h3F, 6'h00, 6'h08, 6'h01, 6'h23};
  bit         script_ov [10] = '{0, 0, 0, 0, 0, 0, 1, 0, 0, 0};

  initial begin
    int m_state = 0;
    int m_next;
    int idx = 0;
    string step_tag = "R1";
    logic [15:0] lfsr = 16'hACE1;
    logic [5:0] cur_op = 6'h00;
    bit cur_ov = 0;
    bit rst_v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      check(step_tag, {28'd0, state_o}, m_state);
      if (m_state == 10 || m_state == 11)
        check("R9", seen, want_word(m_state));
      else if (m_state == 0)
        check("R10", seen, want_word(m_state));
      else
        check("R8", seen, want_word(m_state));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rst_v = (cyc == 151 || cyc == 404 || cyc == 1777);
      if (m_state == 1) begin
        if (idx < 10) begin
          cur_op = script_op[idx];
          cur_ov = script_ov[idx];
        end else begin
          case (lfsr[2:0])
            3'd0, 3'd1: cur_op = 6'h00;
            3'd2: cur_op = 6'h23;
            3'd3: cur_op = 6'h2B;
            3'd4: cur_op = 6'h04;
            3'd5: cur_op = 6'h02;
            default: cur_op = lfsr[10:5];
          endcase
          cur_ov = lfsr[11] & lfsr[12];
        end
        idx++;
      end
      if (m_state == 1 || m_state == 2) opcode = cur_op;
      else opcode = lfsr[8:3];
      alu_ovf = (m_state == 6) ? cur_ov : lfsr[14];
      rst = rst_v;
      m_next = rst_v ? 0 : step(m_state, opcode, alu_ovf);
      step_tag = rst_v ? "R1" : tag_of(m_state, opcode);
      m_state = m_next;
      @(negedge clk);
    end
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule